// File: doc/BRIEF.md
# Direct-Mapped Write-Back Data Cache

This block is a small direct-mapped data cache with write-back policy. It sits between a few requesting pipeline ports and a slower lower memory that moves whole lines. Each port can ask for a word read, a word write, a line read or a line write. A line is four words. Each line slot keeps a tag, a valid bit and a dirty bit.

Completion uses polling. A requester holds its request valid, cycle after cycle, until its `done` bit pulses. Only one requester is served at a time. The first one to be granted owns the cache for the whole access, which includes the miss handling and the hit-delay countdown. On a miss the cache first writes back a dirty victim, then fetches the missing line, then runs its fixed hit delay. The cycle in which the lower memory finishes still counts as not done.

Top module: `dm_wb_cache`

## Requirements
- R1: An address is a word address. Bits [1:0] select the word in the line, the next IDX_W bits select the line slot, and the remaining upper bits form the tag.
- R2: After reset every slot is invalid and clean, and no owner is held. With no request, `done`, `mem_req` and `rdata` are all zero.
- R3: While there is no owner, the lowest-numbered port that has `req_valid` high and a nonzero ID is granted. Any other port sees `done` low until the owner's access completes. Ownership is released on the completing cycle, so another port can be granted no earlier than the next cycle.
- R4: A port whose requester ID is zero is never granted. It never receives `done` and it never causes a lower-memory request.
- R5: On a tag mismatch in a dirty slot, the cache first issues a line write (`mem_write`=1). The address is {stored tag, index, 2'b00} and the data is the victim line. The dirty bit clears in the cycle `mem_done` is seen. The missing line is then fetched.
- R6: On a tag mismatch in a clean or invalid slot, the cache issues a line read (`mem_write`=0) at {requested tag, index, 2'b00}. The line data and the tag are installed, and the slot marked valid, in the cycle `mem_done` is seen.
- R7: A cycle in which `mem_done` is high never reports `done`. Hit processing starts on the following owner cycle.
- R8: Once the line is present, a counter loaded with HIT_DELAY steps down once per owner cycle. The access completes when the counter is zero, and the counter then reloads. A hit completes on owner cycle HIT_DELAY+1. If the lower memory completes on its M+1-th request, a clean miss completes on owner cycle M+HIT_DELAY+2 and a dirty miss on owner cycle 2(M+1)+HIT_DELAY+1.
- R9: `req_op` bit 0 selects write and bit 1 selects line. A word write changes only the addressed word, taking the data from the low 32 bits of the port's write data. A line write replaces the whole line, with word k taken from bits [32k+31:32k]. Both set the dirty bit, and neither writes to the lower memory.
- R10: Read data appears on `rdata` only in the completing cycle of a read. A word read places the word in bits [31:0] with zero above it, and a line read places word k in bits [32k+31:32k]. At all other times `rdata` is zero. Reads never set the dirty bit.
- R11: A cycle in which the owner's port is not presenting makes no progress. No lower request is made and the countdown does not move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NREQ | Request valid, one bit per port |
| req_id | input | NREQ*ID_W | Requester ID per port; zero means no requester |
| req_op | input | NREQ*2 | Operation per port: bit 0 write, bit 1 line |
| req_addr | input | NREQ*ADDR_W | Word address per port |
| req_wdata | input | NREQ*LINE_W | Write data per port (word writes use bits [31:0]) |
| done | output | NREQ | Completion pulse for the port being served |
| rdata | output | LINE_W | Read data in the completing cycle, zero otherwise |
| mem_req | output | 1 | Lower-memory request, held while a miss is being served |
| mem_write | output | 1 | 1 for victim write-back, 0 for line fetch |
| mem_addr | output | ADDR_W | Line-aligned lower-memory address |
| mem_wdata | output | LINE_W | Victim line for write-back |
| mem_rdata | input | LINE_W | Fetched line, valid when mem_done is high |
| mem_done | input | 1 | Lower memory completes the current request this cycle |

## Verification
Two events can coincide: the owner's completion and a waiting port's grant. The bench raises both ports in the same cycle, so that one starts a clean miss while the other waits on a line that would hit. It then checks that the waiting port gets no pulse in the owner's completing cycle, and that its hit latency is counted from the next cycle, so its pulse arrives exactly HIT_DELAY+1 cycles later. The second overlap is the lower memory's completion cycle and hit processing. This is judged by exact latencies for clean and dirty misses, and by a property that forbids `done` while `mem_done` is high.

// File: rtl/dm_wb_cache.sv
module dm_wb_cache #(
  parameter int ADDR_W    = 8,
  parameter int IDX_W     = 2,
  parameter int WORD_W    = 32,
  parameter int ID_W      = 2,
  parameter int NREQ      = 2,
  parameter int HIT_DELAY = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NREQ-1:0]          req_valid,
  input  logic [NREQ*ID_W-1:0]     req_id,
  input  logic [NREQ*2-1:0]        req_op,
  input  logic [NREQ*ADDR_W-1:0]   req_addr,
  input  logic [NREQ*WORD_W*4-1:0] req_wdata,
  output logic [NREQ-1:0]          done,
  output logic [WORD_W*4-1:0]      rdata,
  output logic                     mem_req,
  output logic                     mem_write,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic [WORD_W*4-1:0]      mem_wdata,
  input  logic [WORD_W*4-1:0]      mem_rdata,
  input  logic                     mem_done
);
  localparam int OFF_W  = 2;
  localparam int LINE_W = WORD_W * (1 << OFF_W);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int LINES  = 1 << IDX_W;
  localparam int CW     = $clog2(HIT_DELAY + 2);
  localparam int SW     = (NREQ > 1) ? $clog2(NREQ) : 1;

  logic [LINE_W-1:0] data_q [LINES];
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINES-1:0]  vld_q, dirty_q;
  logic [ID_W-1:0]   owner_q;
  logic [CW-1:0]     cnt_q;

  logic              found;
  logic [SW-1:0]     sel;
  logic [ID_W-1:0]   cur_id;
  logic [1:0]        cur_op;
  logic [ADDR_W-1:0] cur_addr;
  logic [LINE_W-1:0] cur_wdata;

  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int p = 0; p < NREQ; p++) begin
      if (!found && req_valid[p] && req_id[p*ID_W +: ID_W] != '0 &&
          (owner_q == '0 || req_id[p*ID_W +: ID_W] == owner_q)) begin
        found = 1'b1;
        sel   = SW'(p);
      end
    end
  end

  assign cur_id    = req_id[sel*ID_W +: ID_W];
  assign cur_op    = req_op[sel*2 +: 2];
  assign cur_addr  = req_addr[sel*ADDR_W +: ADDR_W];
  assign cur_wdata = req_wdata[sel*LINE_W +: LINE_W];

  logic [TAG_W-1:0] a_tag;
  logic [IDX_W-1:0] a_idx;
  logic [OFF_W-1:0] a_off;
  assign {a_tag, a_idx, a_off} = cur_addr;

  logic is_write, is_line, hit, miss, fin;
  assign is_write = cur_op[0];
  assign is_line  = cur_op[1];
  assign hit      = vld_q[a_idx] && tag_q[a_idx] == a_tag;
  assign miss     = found && !hit;
  assign fin      = found && hit && cnt_q == '0;

  assign mem_req   = miss;
  assign mem_write = dirty_q[a_idx];
  assign mem_addr  = dirty_q[a_idx] ? {tag_q[a_idx], a_idx, {OFF_W{1'b0}}}
                                    : {a_tag, a_idx, {OFF_W{1'b0}}};
  assign mem_wdata = data_q[a_idx];

  always_comb begin
    for (int p = 0; p < NREQ; p++) done[p] = fin && sel == SW'(p);
    rdata = '0;
    if (fin && !is_write) begin
      if (is_line) rdata = data_q[a_idx];
      else rdata[WORD_W-1:0] = data_q[a_idx][a_off*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q   <= '0;
      dirty_q <= '0;
      owner_q <= '0;
      cnt_q   <= CW'(HIT_DELAY);
    end else begin
      if (found && owner_q == '0) owner_q <= cur_id;
      if (miss && mem_done) begin
        if (dirty_q[a_idx]) begin
          dirty_q[a_idx] <= 1'b0;
        end else begin
          vld_q[a_idx] <= 1'b1;
          tag_q[a_idx] <= a_tag;
        end
      end
      if (fin) begin
        cnt_q   <= CW'(HIT_DELAY);
        owner_q <= '0;
        if (is_write) dirty_q[a_idx] <= 1'b1;
      end else if (found && hit) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (miss && mem_done && !dirty_q[a_idx]) data_q[a_idx] <= mem_rdata;
    if (fin && is_write) begin
      if (is_line) data_q[a_idx] <= cur_wdata;
      else data_q[a_idx][a_off*WORD_W +: WORD_W] <= cur_wdata[WORD_W-1:0];
    end
  end
endmodule

module dm_wb_cache_chk #(
  parameter int ADDR_W = 8,
  parameter int ID_W   = 2,
  parameter int NREQ   = 2,
  parameter int LINE_W = 128
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NREQ-1:0]      req_valid,
  input logic [NREQ*ID_W-1:0] req_id,
  input logic [NREQ-1:0]      done,
  input logic [LINE_W-1:0]    rdata,
  input logic                 mem_req,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic                 mem_done
);
  logic [NREQ-1:0] zid;
  always_comb
    for (int p = 0; p < NREQ; p++) zid[p] = req_id[p*ID_W +: ID_W] == '0;

  p_single_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done));
  p_done_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done & ~req_valid) == '0);
  p_no_grant_id0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done & zid) == '0);
  p_mem_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (req_valid & ~zid) != '0);
  p_line_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> mem_addr[1:0] == 2'b00);
  p_lower_cycle_not_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_done) |-> done == '0);
  p_rdata_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done == '0 |-> rdata == '0);
endmodule

bind dm_wb_cache dm_wb_cache_chk #(
  .ADDR_W(ADDR_W), .ID_W(ID_W), .NREQ(NREQ), .LINE_W(LINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_id(req_id),
  .done(done), .rdata(rdata), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_done(mem_done)
);

// File: tb/sim_dm_wb_cache.sv
module sim_dm_wb_cache;
  localparam int AW = 8, IW = 2, NR = 2, C = 2, M = 3, LW = 128;
  localparam int CLEAN = M + C + 2, HIT = C + 1, DIRTY = 2 * (M + 1) + C + 1;

  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic [NR-1:0]    rv = '0;
  logic [NR*IW-1:0] rid = '0;
  logic [NR*2-1:0]  rop = '0;
  logic [NR*AW-1:0] raddr = '0;
  logic [NR*LW-1:0] rwd = '0;
  logic [NR-1:0]    done;
  logic [LW-1:0]    rdata, mem_wdata, mem_rdata;
  logic             mem_req, mem_write, mem_done;
  logic [AW-1:0]    mem_addr;

  dm_wb_cache #(.ADDR_W(AW), .IDX_W(2), .WORD_W(32), .ID_W(IW), .NREQ(NR),
                .HIT_DELAY(C)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(rv), .req_id(rid), .req_op(rop),
    .req_addr(raddr), .req_wdata(rwd), .done(done), .rdata(rdata),
    .mem_req(mem_req), .mem_write(mem_write), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_done(mem_done));

  logic [LW-1:0] lmem [64];
  int lcnt;
  assign mem_done  = mem_req && lcnt == 0;
  assign mem_rdata = lmem[mem_addr[AW-1:2]];
  initial
    for (int i = 0; i < 64; i++)
      for (int k = 0; k < 4; k++) lmem[i][k*32 +: 32] = 32'h1000_0000 + 32'(i * 4 + k);
  always @(posedge clk) begin
    if (!rst_n) lcnt <= M;
    else if (mem_req) begin
      if (lcnt == 0) begin
        if (mem_write) lmem[mem_addr[AW-1:2]] <= mem_wdata;
        lcnt <= M;
      end else lcnt <= lcnt - 1;
    end
  end

  int checks = 0, fails = 0;
  task automatic check(input bit ok, input string req, input logic [LW-1:0] act, input logic [LW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk_line(input logic [31:0] b);
    return {b + 32'd3, b + 32'd2, b + 32'd1, b};
  endfunction

  logic fm_req, fm_wr;
  logic [AW-1:0] fm_addr;

  task automatic do_req(input int p, input logic [IW-1:0] id, input logic [1:0] op,
                        input logic [AW-1:0] a, input logic [LW-1:0] wd,
                        output int n, output logic [LW-1:0] rd);
    bit got = 0;
    n = 0; rd = '0;
    @(negedge clk);
    rv[p] = 1'b1; rid[p*IW +: IW] = id; rop[p*2 +: 2] = op;
    raddr[p*AW +: AW] = a; rwd[p*LW +: LW] = wd;
    while (!got && n < 200) begin
      #2; n++;
      if (n == 1) begin fm_req = mem_req; fm_wr = mem_write; fm_addr = mem_addr; end
      if (done[p]) begin got = 1; rd = rdata; end
      else @(negedge clk);
    end
    @(negedge clk);
    rv[p] = 1'b0;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] wd;
    logic [7:0]  cyc;
    logic [31:0] ex;
  } vec_t;

  localparam vec_t VEC [12] = '{
    '{2'b00, 8'h05, 32'h0,         8'(CLEAN), 32'h1000_0005},
    '{2'b00, 8'h06, 32'h0,         8'(HIT),   32'h1000_0006},
    '{2'b01, 8'h07, 32'hA5A5_0007, 8'(HIT),   32'h0},
    '{2'b00, 8'h06, 32'h0,         8'(HIT),   32'h1000_0006},
    '{2'b00, 8'h07, 32'h0,         8'(HIT),   32'hA5A5_0007},
    '{2'b00, 8'h15, 32'h0,         8'(DIRTY), 32'h1000_0015},
    '{2'b00, 8'h05, 32'h0,         8'(CLEAN), 32'h1000_0005},
    '{2'b00, 8'h07, 32'h0,         8'(HIT),   32'hA5A5_0007},
    '{2'b11, 8'h22, 32'hC0DE_0000, 8'(CLEAN), 32'h0},
    '{2'b10, 8'h21, 32'h0,         8'(HIT),   32'hC0DE_0000},
    '{2'b00, 8'h23, 32'h0,         8'(HIT),   32'hC0DE_0003},
    '{2'b00, 8'h33, 32'h0,         8'(DIRTY), 32'h1000_0033}
  };

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, d0, d1;
    logic [LW-1:0] rd, exp;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #2;
    check(done == '0 && !mem_req && rdata == '0, "R2 idle outputs", {mem_req, done}, '0);

    foreach (VEC[i]) begin
      do_req(0, 2'd1, VEC[i].op, VEC[i].addr,
             VEC[i].op[1] ? mk_line(VEC[i].wd) : {96'b0, VEC[i].wd}, n, rd);
      check(n == int'(VEC[i].cyc), $sformatf("R8 R6 R5 latency vec %0d", i), LW'(n), LW'(VEC[i].cyc));
      if (VEC[i].op[0]) exp = '0;
      else if (VEC[i].op[1]) exp = mk_line(VEC[i].ex);
      else exp = {96'b0, VEC[i].ex};
      check(rd == exp, $sformatf("R1 R9 R10 data vec %0d", i), rd, exp);
    end
    check(lmem[1][127:96] == 32'hA5A5_0007, "R5 victim written back", LW'(lmem[1][127:96]), LW'(32'hA5A5_0007));
    check(lmem[8] == mk_line(32'hC0DE_0000), "R9 line write-back whole", lmem[8], mk_line(32'hC0DE_0000));

    // R4: ID zero never granted
    @(negedge clk);
    rv[0] = 1; rid[1:0] = 2'd0; rop[1:0] = 2'b00; raddr[7:0] = 8'h05;
    for (int k = 0; k < 6; k++) begin
      #2;
      check(done == '0 && !mem_req, "R4 id zero ignored", {mem_req, done}, '0);
      @(negedge clk);
    end
    rv[0] = 0;

    // R3: simultaneous requests, completion then grant
    @(negedge clk);
    rv = 2'b11; rid = {2'd2, 2'd1}; rop = '0; raddr = {8'h05, 8'h09};
    d0 = 0; d1 = 0;
    for (int k = 1; k <= 30; k++) begin
      #2;
      if (done[0] && d0 == 0) d0 = k;
      if (done[1] && d1 == 0) d1 = k;
      if (done[0] && done[1]) check(0, "R3 two done pulses", LW'(done), LW'(1));
      @(negedge clk);
      if (d0 != 0) rv[0] = 0;
      if (d1 != 0) rv[1] = 0;
    end
    check(d0 == CLEAN, "R3 owner latency", LW'(d0), LW'(CLEAN));
    check(d1 == CLEAN + HIT, "R3 waiter granted after release", LW'(d1), LW'(CLEAN + HIT));

    // R11: owner absent stalls; other port stays locked out
    @(negedge clk);
    rv[0] = 1; rid[1:0] = 2'd1; rop[1:0] = 2'b00; raddr[7:0] = 8'h0D;
    #2; check(done == '0, "R11 first cycle", LW'(done), '0);
    @(negedge clk); #2; check(done == '0, "R11 second cycle", LW'(done), '0);
    @(negedge clk);
    rv[0] = 0; rv[1] = 1; rid[3:2] = 2'd2; rop[3:2] = 2'b00; raddr[15:8] = 8'h05;
    for (int k = 0; k < 3; k++) begin
      #2;
      check(done == '0 && !mem_req, "R11 R3 owner absent", {mem_req, done}, '0);
      @(negedge clk);
    end
    rv[1] = 0; rv[0] = 1;
    n = 2;
    for (int k = 0; k < 40 && n < 100; k++) begin
      #2; n++;
      if (done[0]) begin
        rd = rdata;
        k = 40;
      end else @(negedge clk);
    end
    @(negedge clk); rv[0] = 0;
    check(n == CLEAN, "R11 presented cycles", LW'(n), LW'(CLEAN));
    check(rd == {96'b0, 32'h1000_000D}, "R11 data", rd, {96'b0, 32'h1000_000D});
    do_req(1, 2'd2, 2'b00, 8'h05, '0, n, rd);
    check(n == HIT, "R3 other port after release", LW'(n), LW'(HIT));

    // R5: write-back address and order
    do_req(0, 2'd1, 2'b01, 8'h0E, {96'b0, 32'h5A5A_000E}, n, rd);
    check(n == HIT, "R9 word write hit", LW'(n), LW'(HIT));
    do_req(0, 2'd1, 2'b00, 8'h1E, '0, n, rd);
    check(fm_req && fm_wr, "R5 write-back first", {fm_req, fm_wr}, 2'b11);
    check(fm_addr == 8'h0C, "R5 victim address", LW'(fm_addr), LW'(8'h0C));
    check(n == DIRTY, "R5 R7 dirty latency", LW'(n), LW'(DIRTY));
    check(rd == {96'b0, 32'h1000_001E}, "R6 refill data", rd, {96'b0, 32'h1000_001E});
    check(lmem[3][95:64] == 32'h5A5A_000E, "R5 victim data", LW'(lmem[3][95:64]), LW'(32'h5A5A_000E));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule